// File: doc/BRIEF.md
# Filtered External Interrupt Detector

This block watches one external interrupt pin and turns a qualified transition or level on it into a pending interrupt request. The raw pin first crosses into the system clock domain through a short chain of flops. A digital noise filter then takes samples of the synchronised level on a tick. A new level is passed on only after a run of consecutive equal samples. In normal (high-speed) operation the sampling-interval tick is used and the run is short. When the system runs from the low-speed clock, the low-speed clock tick is used and a longer run is needed. This gives a wider rejection window that is counted in low-speed periods.

The filtered level feeds a trigger detector that looks for a falling edge, a rising edge, either edge or a high level, as selected by software. A detection sets a sticky pending latch only while the global interrupt master enable and the channel enable are both set. The latch is cleared by an explicit clear pulse. A per-channel clock-enable bit freezes the synchroniser, the filter and the detector while it is low, so no request can be detected. After a change of trigger mode, or on the cycle the clock enable returns, edge detection is masked for one cycle, so that the change cannot produce a false edge. Priority arbitration and vectoring belong to the interrupt controller that consumes `irq_pend`.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset `irq_pend` is 0 and `filt_level` equals the pin idle level (1 by default).
- R2: In high-speed mode (`slow_mode`=0) the synchronised pin level reaches `filt_level` only after 3 consecutive equal samples taken on `samp_tick`. A pulse seen on fewer samples is discarded.
- R3: In low-speed mode (`slow_mode`=1) the filter samples on `slow_tick` and needs 6 consecutive equal samples. A pulse of about 40 system cycles at 16 cycles per tick is discarded.
- R4: With `trig_mode`=2'b00 a 1-to-0 change of `filt_level` sets `irq_pend`.
- R5: With `trig_mode`=2'b01 a 0-to-1 change of `filt_level` sets `irq_pend`.
- R6: With `trig_mode`=2'b10 either change of `filt_level` sets `irq_pend`.
- R7: With `trig_mode`=2'b11 a high `filt_level` sets `irq_pend` on every cycle.
- R8: `irq_pend` can be set only when `master_en` and `chan_en` are both 1 in the detecting cycle.
- R9: While `clk_en` is 0, `filt_level` holds and no detection occurs. On the first cycle after `clk_en` rises, edge detection is masked.
- R10: `irq_pend` stays set until `pend_clr` is pulsed. If a clear and a detection fall in the same cycle, the latch stays set.
- R11: On a cycle where `trig_mode` differs from its value in the previous cycle, no detection is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_tick | input | 1 | Sampling-interval tick, one cycle wide |
| slow_tick | input | 1 | Low-speed clock period tick, one cycle wide |
| slow_mode | input | 1 | 1 when the system runs in low-speed mode |
| clk_en | input | 1 | Per-channel clock enable; resets the channel's activity to stopped |
| master_en | input | 1 | Global interrupt master enable |
| chan_en | input | 1 | Per-channel interrupt enable |
| trig_mode | input | 2 | 00 falling, 01 rising, 10 both edges, 11 high level |
| irq_pin | input | 1 | Asynchronous external pin |
| pend_clr | input | 1 | Clear pulse for the pending latch |
| irq_pend | output | 1 | Pending interrupt request |
| filt_level | output | 1 | Filtered pin level |

## Verification
The assertions check the following on every cycle. The latch never rises without both enables and the clock enable in the previous cycle. It holds until a clear. It ignores nothing while set. The filtered level moves only after an active tick, and it freezes while the clock is stopped. A change of trigger mode never raises the latch. The exact filter run lengths in both speed modes, the glitch rejection, and each trigger flavour against real pin waveforms can only be shown by the bench. The bench compares a behavioural model against the block on every cycle while the pin scenarios run.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_FALL  = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_BOTH  = 2'b10,
    TRIG_LEVEL = 2'b11
  } trig_e;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)   chain[i] <= RST_LVL;
        else if (run) chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eid_filter.sv
module eid_filter #(
  parameter int   HS_RUN  = 3,
  parameter int   LS_RUN  = 6,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic slow,
  input  logic d,
  output logic q
);
  localparam int MAXRUN = (HS_RUN > LS_RUN) ? HS_RUN : LS_RUN;
  localparam int CW     = $clog2(MAXRUN + 1);

  logic          cand;
  logic [CW-1:0] cnt;
  logic [CW:0]   thr;
  logic [CW:0]   cnt_inc;

  assign thr     = slow ? (CW+1)'(LS_RUN) : (CW+1)'(HS_RUN);
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= RST_LVL;
      cnt  <= CW'(MAXRUN);
      q    <= RST_LVL;
    end else if (run && tick) begin
      if (d != cand) begin
        cand <= d;
        cnt  <= CW'(1);
      end else begin
        if (cnt_inc <= (CW+1)'(MAXRUN)) cnt <= cnt_inc[CW-1:0];
        if (cnt_inc >= thr)             q   <= d;
      end
    end
  end
endmodule

// File: rtl/eid_detect.sv
module eid_detect
  import ext_irq_pkg::*;
#(
  parameter bit   HAS_LEVEL = 1'b1,
  parameter logic RST_LVL   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       arm,
  input  logic [1:0] mode,
  input  logic       lvl,
  input  logic       clr,
  output logic       pend
);
  logic       prev;
  logic [1:0] mode_q;
  logic       run_q;
  logic       hit;
  logic       det;

  always_comb begin
    unique case (trig_e'(mode))
      TRIG_FALL:  hit = ~lvl &  prev;
      TRIG_RISE:  hit =  lvl & ~prev;
      TRIG_BOTH:  hit =  lvl ^  prev;
      TRIG_LEVEL: hit = HAS_LEVEL ? lvl : (lvl ^ prev);
      default:    hit = 1'b0;
    endcase
  end

  assign det = run & run_q & arm & (mode == mode_q) & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= RST_LVL;
      mode_q <= 2'b00;
      run_q  <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (run) prev <= lvl;
      mode_q <= mode;
      run_q  <= run;
      pend   <= det | (pend & ~clr);
    end
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int   SYNC_STAGES = 2,
  parameter int   HS_RUN      = 3,
  parameter int   LS_RUN      = 6,
  parameter bit   HAS_LEVEL   = 1'b1,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_tick,
  input  logic       slow_tick,
  input  logic       slow_mode,
  input  logic       clk_en,
  input  logic       master_en,
  input  logic       chan_en,
  input  logic [1:0] trig_mode,
  input  logic       irq_pin,
  input  logic       pend_clr,
  output logic       irq_pend,
  output logic       filt_level
);
  logic pin_s;
  logic tick;

  assign tick = slow_mode ? slow_tick : samp_tick;

  eid_sync #(.STAGES(SYNC_STAGES), .RST_LVL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(clk_en), .d(irq_pin), .q(pin_s)
  );

  eid_filter #(.HS_RUN(HS_RUN), .LS_RUN(LS_RUN), .RST_LVL(IDLE_LVL)) u_filt (
    .clk(clk), .rst_n(rst_n), .run(clk_en), .tick(tick), .slow(slow_mode),
    .d(pin_s), .q(filt_level)
  );

  eid_detect #(.HAS_LEVEL(HAS_LEVEL), .RST_LVL(IDLE_LVL)) u_det (
    .clk(clk), .rst_n(rst_n), .run(clk_en), .arm(master_en & chan_en),
    .mode(trig_mode), .lvl(filt_level), .clr(pend_clr), .pend(irq_pend)
  );
endmodule

// File: rtl/ext_irq_detect_sva.sv
module ext_irq_detect_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       samp_tick,
  input logic       slow_tick,
  input logic       slow_mode,
  input logic       clk_en,
  input logic       master_en,
  input logic       chan_en,
  input logic [1:0] trig_mode,
  input logic       irq_pin,
  input logic       pend_clr,
  input logic       irq_pend,
  input logic       filt_level
);
  // R8: a new request needs both enables (and a running clock, R9)
  a_r8_enables_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(master_en && chan_en && clk_en));

  // R10: the latch is sticky without a clear
  a_r10_hold_until_clr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend && !pend_clr |=> irq_pend);

  // R2 / R3: the filtered level moves only after an active tick
  a_r2_filt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_level) |-> $past(clk_en && (slow_mode ? slow_tick : samp_tick)));

  // R9: stopped clock freezes the filter
  a_r9_gated_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(filt_level));

  // R9: stopped clock plus clear leaves the latch empty
  a_r9_gated_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en && pend_clr |=> !irq_pend);

  // R11: a mode change cycle never raises the latch
  a_r11_mode_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode != $past(trig_mode)) && !irq_pend |=> !irq_pend);
endmodule

bind ext_irq_detect ext_irq_detect_sva u_sva (.*);

// File: tb/ext_irq_detect_test.sv
`timescale 1ns/1ps
module ext_irq_detect_test;
  localparam int HS = 3;
  localparam int LS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_tick = 1'b0, slow_tick = 1'b0, slow_mode = 1'b0;
  logic clk_en = 1'b0, master_en = 1'b0, chan_en = 1'b0;
  logic [1:0] trig_mode = 2'b00;
  logic irq_pin = 1'b1, pend_clr = 1'b0;
  logic irq_pend, filt_level;

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_detect uut (.*);

  // behavioural reference model
  bit m_s1, m_s2, m_cand, m_filt, m_prev, m_pend, m_enq;
  logic [1:0] m_modeq;
  int m_cnt;

  always @(posedge clk) begin
    bit det, match, tk;
    int thr;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_cand = 1; m_cnt = LS; m_filt = 1; m_prev = 1;
      m_pend = 0; m_modeq = 2'b00; m_enq = 0;
    end else begin
      det = 0;
      if (clk_en) begin
        case (trig_mode)
          2'b00: match = !m_filt && m_prev;
          2'b01: match = m_filt && !m_prev;
          2'b10: match = m_filt != m_prev;
          default: match = m_filt;
        endcase
        det = master_en && chan_en && m_enq && (trig_mode == m_modeq) && match;
        m_prev = m_filt;
        tk  = slow_mode ? slow_tick : samp_tick;
        thr = slow_mode ? LS : HS;
        if (tk) begin
          if (m_s2 != m_cand) begin m_cand = m_s2; m_cnt = 1; end
          else begin
            if (m_cnt + 1 >= thr) m_filt = m_s2;
            if (m_cnt < LS) m_cnt++;
          end
        end
        m_s2 = m_s1; m_s1 = irq_pin;
      end
      m_pend = det || (m_pend && !pend_clr);
      m_modeq = trig_mode; m_enq = clk_en;
    end
  end

  // tick generation and every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    samp_tick <= (cyc % 4 == 0);
    slow_tick <= (cyc % 16 == 3);
    if (rst_n && !done) begin
      checks++;
      if (irq_pend !== m_pend || filt_level !== m_filt) begin
        errors++;
        $display("FAIL %s model: pend=%0b filt=%0b expected pend=%0b filt=%0b",
                 cur_req, irq_pend, filt_level, m_pend, m_filt);
      end
    end
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic clear_pend();
    @(negedge clk); pend_clr = 1;
    @(negedge clk); pend_clr = 0;
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    expect_bit("R1 pend", irq_pend, 1'b0);
    expect_bit("R1 filt", filt_level, 1'b1);

    clk_en = 1; master_en = 1; chan_en = 1; trig_mode = 2'b00;
    wait_cyc(10);

    cur_req = "R2";
    irq_pin = 0; wait_cyc(5); irq_pin = 1; wait_cyc(20);
    expect_bit("R2 glitch filt", filt_level, 1'b1);
    expect_bit("R2 glitch pend", irq_pend, 1'b0);

    cur_req = "R4";
    irq_pin = 0; wait_cyc(24);
    expect_bit("R4 filt", filt_level, 1'b0);
    expect_bit("R4 pend", irq_pend, 1'b1);

    cur_req = "R10";
    wait_cyc(5);
    expect_bit("R10 held", irq_pend, 1'b1);
    clear_pend();
    expect_bit("R10 cleared", irq_pend, 1'b0);

    cur_req = "R11";
    trig_mode = 2'b01; wait_cyc(4);
    expect_bit("R11 no false edge", irq_pend, 1'b0);

    cur_req = "R5";
    irq_pin = 1; wait_cyc(24);
    expect_bit("R5 rise", irq_pend, 1'b1);
    clear_pend();

    cur_req = "R6";
    trig_mode = 2'b10; wait_cyc(2);
    irq_pin = 0; wait_cyc(24);
    expect_bit("R6 fall", irq_pend, 1'b1);
    clear_pend();
    irq_pin = 1; wait_cyc(24);
    expect_bit("R6 rise", irq_pend, 1'b1);
    clear_pend();

    cur_req = "R7";
    trig_mode = 2'b11; wait_cyc(3);
    expect_bit("R7 level", irq_pend, 1'b1);
    cur_req = "R10";
    clear_pend();
    expect_bit("R10 detect beats clear", irq_pend, 1'b1);
    cur_req = "R7";
    irq_pin = 0; wait_cyc(24);
    clear_pend(); wait_cyc(2);
    expect_bit("R7 low no set", irq_pend, 1'b0);

    cur_req = "R8";
    trig_mode = 2'b00; irq_pin = 1; wait_cyc(24);
    master_en = 0; irq_pin = 0; wait_cyc(24);
    expect_bit("R8 master off", irq_pend, 1'b0);
    master_en = 1; chan_en = 0; irq_pin = 1; wait_cyc(24);
    trig_mode = 2'b01; wait_cyc(1); irq_pin = 0; wait_cyc(24);
    irq_pin = 1; wait_cyc(24);
    expect_bit("R8 chan off", irq_pend, 1'b0);
    chan_en = 1; trig_mode = 2'b00; wait_cyc(2);

    cur_req = "R9";
    clk_en = 0; irq_pin = 0; wait_cyc(40);
    expect_bit("R9 frozen filt", filt_level, 1'b1);
    expect_bit("R9 no detect", irq_pend, 1'b0);
    clk_en = 1; wait_cyc(30);
    expect_bit("R9 resumes", filt_level, 1'b0);
    clear_pend();

    cur_req = "R3";
    irq_pin = 1; wait_cyc(24);
    slow_mode = 1; wait_cyc(4);
    irq_pin = 0; wait_cyc(40); irq_pin = 1; wait_cyc(120);
    expect_bit("R3 slow glitch", filt_level, 1'b1);
    expect_bit("R3 slow glitch pend", irq_pend, 1'b0);
    irq_pin = 0; wait_cyc(60);
    expect_bit("R3 not yet", filt_level, 1'b1);
    wait_cyc(60);
    expect_bit("R3 accept", filt_level, 1'b0);
    expect_bit("R3 pend", irq_pend, 1'b1);

    wait_cyc(4);
    finish_run();
  end
endmodule